// File: doc/BRIEF.md
# Reset Source Status Controller

This block records why the system last came out of reset and reports it through a single byte-wide status register. It watches four reset causes: an external active-low reset pin behind a counting glitch filter, a brownout comparator, a watchdog time-out strobe and the power-on reset of the block itself. It drives the system reset output from these causes. A live low-voltage flag appears in the same byte. A low-voltage interrupt request fires on each new dip.

The status register sits at one bus address and is read-only. A write to that address loads a write-only watchdog control byte, which goes out to the watchdog counter and cannot be read back. Reading the register clears the four cause flags. The low-voltage flag is not stored: it shows the qualified comparator level as it is now. Both the low-voltage flag and its interrupt are gated by the brownout enable. All comparator and pin inputs are assumed to be synchronous to `clk`.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n` is 0. After release, `wdt_ctrl` is 0x00 and a status read returns 0x40 (power-on flag only, with `lv_trip` low). `sys_rst_n` rises at the first edge after release when no cause is active.
- R2: A read (`bus_sel` and `bus_rd`) returns bit 7 = pin reset, bit 6 = power-on/brownout, bit 5 = stop-mode recovery, bit 4 = watchdog time-out, bit 0 = live low-voltage, bits 3..1 = 0. `bus_rdata` is 0x00 when no read is in progress.
- R3: The clock edge that ends a read cycle clears bits 7..4.
- R4: Bit 0 equals `bo_en & lv_trip` in the same cycle. Reads and writes have no effect on it.
- R5: `lv_irq` is high for exactly one cycle: the first cycle in which `bo_en & lv_trip` is high, and only if `lv_irq_en` is 1.
- R6: With `bo_en` low, bit 0 and `lv_irq` stay 0, and `bo_trip` causes no reset and sets no flag.
- R7: A write (`bus_sel` and `bus_wr`) loads `bus_wdata` into `wdt_ctrl` at the clock edge and leaves the status flags unchanged.
- R8: When `ext_rst_n` is sampled low on FILT_LEN consecutive clocks, `sys_rst_n` goes low and bit 7 is set. A low pulse of FILT_LEN-1 clocks has no effect.
- R9: A pin or watchdog reset that happens while `stop_mode` is 1 also sets bit 5.
- R10: A one-cycle `wdt_timeout` strobe sets bit 4 and drives `sys_rst_n` low for one cycle.
- R11: A new reset event sets its own flags and clears the other cause flags. If an event and a read fall in the same cycle, the event's flags remain.
- R12: While `bo_en & bo_trip` is high, `sys_rst_n` is low and the status shows bit 6 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| ext_rst_n | input | 1 | External reset pin, active low |
| bo_en | input | 1 | Brownout detection enable, also gates low-voltage detection |
| bo_trip | input | 1 | Brownout comparator, 1 = supply below trip |
| lv_trip | input | 1 | Low-voltage comparator, 1 = supply below threshold |
| lv_irq_en | input | 1 | Low-voltage interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| stop_mode | input | 1 | Device is in stop mode |
| bus_sel | input | 1 | Register address selected |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sys_rst_n | output | 1 | System reset, active low |
| lv_irq | output | 1 | Low-voltage interrupt request pulse |
| wdt_ctrl | output | 8 | Watchdog control byte |

## Verification
`bus_rdata`, bit 0 and `lv_irq` are combinational, so the bench samples them 1 ns after driving, inside the same cycle. Flag changes and `wdt_ctrl` land at the edge that closes the stimulus cycle. `sys_rst_n` follows its cause one edge later. For the pin, that is FILT_LEN+2 edges after the pin is driven low: one sample register, FILT_LEN counts, then the output register. The bench drives inputs on falling edges, counts exactly those edges before each sample, and reads status back through the bus so that each flag's set and clear is seen at the ports.

// File: rtl/rst_cause_pkg.sv
// Shared definitions for the reset source status controller.
// Assumes an 8-bit status byte with the bit positions below.
package rst_cause_pkg;
    localparam int STAT_W   = 8;
    localparam int PIN_BIT  = 7;
    localparam int PWR_BIT  = 6;
    localparam int STOP_BIT = 5;
    localparam int WDT_BIT  = 4;
    localparam int LV_BIT   = 0;

    // Latched cause flags, listed from MSB to LSB of the status nibble
    typedef struct packed {
        logic pin;
        logic pwr;
        logic stop;
        logic wdt;
    } cause_flags_t;

    // Winning reset event in a cycle
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_PWR  = 2'd1,
        EV_PIN  = 2'd2,
        EV_WDT  = 2'd3
    } evt_src_t;

    // Packs the latched flags and the live low-voltage bit into the status byte
    function automatic logic [STAT_W-1:0] pack_status(cause_flags_t f, logic lv);
        logic [STAT_W-1:0] b;
        b           = '0;
        b[PIN_BIT]  = f.pin;
        b[PWR_BIT]  = f.pwr;
        b[STOP_BIT] = f.stop;
        b[WDT_BIT]  = f.wdt;
        b[LV_BIT]   = lv;
        return b;
    endfunction
endpackage

// File: rtl/rst_pin_filter.sv
// Glitch filter for the external active-low reset pin.
// The pin is sampled once, then a counter must see FILT_LEN consecutive low
// samples before filt_low asserts; any high sample clears the count.
// ext_evt pulses for one cycle when filt_low first asserts.
// Assumes the pin is already synchronous to clk.
module rst_pin_filter #(
    parameter int FILT_LEN = 4,
    localparam int CNT_W   = $clog2(FILT_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic filt_low,
    output logic ext_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_LEN);

    logic             pin_q;
    logic [CNT_W-1:0] cnt;
    logic             filt_q;

    // Register the raw pin sample
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= pin_n;
    end

    // Count consecutive low samples, saturate at FILT_LEN, clear on high
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (pin_q)      cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Remember the previous filter state to find its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) filt_q <= 1'b0;
        else        filt_q <= filt_low;
    end

    // Qualified low level and its one-cycle start marker
    always_comb begin
        filt_low = (cnt == CNT_MAX);
        ext_evt  = filt_low & ~filt_q;
    end

    // R8
    // filt_low can only start after a low pin sample.
    filt_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_low) |-> $past(!pin_q));

    // R8
    // The event marker never lasts two cycles.
    ext_evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_evt |=> !ext_evt);
endmodule

// File: rtl/lv_detect.sv
// Low-voltage flag and interrupt generation.
// The live flag is the comparator qualified by the brownout enable; it is
// never stored. The interrupt is a one-cycle pulse on its rising edge.
// Assumes lv_trip is synchronous to clk.
module lv_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic bo_en,
    input  logic lv_trip,
    input  logic irq_en,
    output logic lv_live,
    output logic lv_irq
);
    logic lv_q;

    // Keep the previous qualified level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lv_q <= 1'b0;
        else        lv_q <= lv_live;
    end

    // Live qualified flag and the rising-edge request
    always_comb begin
        lv_live = bo_en & lv_trip;
        lv_irq  = irq_en & lv_live & ~lv_q;
    end

    // R5
    // The request never spans two cycles.
    lv_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lv_irq |=> !lv_irq);

    // R6
    // Nothing is reported while brownout detection is off.
    lv_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bo_en |-> (!lv_live && !lv_irq));
endmodule

// File: rtl/rst_status_reg.sv
// Cause flag register. A read clears every flag; a reset event in the same
// cycle then loads its own flags, which replace the others.
// Assumes at most one event source is presented per cycle (priority is
// resolved by the parent).
module rst_status_reg
    import rst_cause_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  evt_src_t     src,
    input  logic         stop_mode,
    input  logic         rd_clr,
    output cause_flags_t flags
);
    cause_flags_t evt_flags;
    cause_flags_t flags_nxt;

    // Flag pattern for the event in this cycle
    always_comb begin
        evt_flags = '0;
        unique case (src)
            EV_PWR:  evt_flags.pwr = 1'b1;
            EV_PIN:  begin
                evt_flags.pin  = 1'b1;
                evt_flags.stop = stop_mode;
            end
            EV_WDT:  begin
                evt_flags.wdt  = 1'b1;
                evt_flags.stop = stop_mode;
            end
            default: evt_flags = '0;
        endcase
    end

    // Read clear first, then the event overrides
    always_comb begin
        flags_nxt = flags;
        if (rd_clr)         flags_nxt = '0;
        if (src != EV_NONE) flags_nxt = evt_flags;
    end

    // Store the flags; power-on sets the power flag
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '{pin: 1'b0, pwr: 1'b1, stop: 1'b0, wdt: 1'b0};
        else        flags <= flags_nxt;
    end

    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && src == EV_NONE) |=> flags == '0);

    // R11
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src != EV_NONE) |=> (flags != '0 && $countones(flags) <= 2));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && src == EV_NONE) |=> $stable(flags));
endmodule

// File: rtl/rst_cause_ctrl.sv
// Top of the reset source status controller.
// Combines the pin filter, brownout, watchdog and power-on causes into a
// registered system reset and a cause register. Reads of the shared address
// return status; writes load the write-only watchdog control byte.
// Assumes all inputs are synchronous to clk.
module rst_cause_ctrl
    import rst_cause_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_n,
    input  logic              bo_en,
    input  logic              bo_trip,
    input  logic              lv_trip,
    input  logic              lv_irq_en,
    input  logic              wdt_timeout,
    input  logic              stop_mode,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    output logic              sys_rst_n,
    output logic              lv_irq,
    output logic [STAT_W-1:0] wdt_ctrl
);
    logic         filt_low;
    logic         ext_evt;
    logic         lv_live;
    logic         bo_qual;
    logic         rd_stb;
    logic         wr_stb;
    evt_src_t     src;
    cause_flags_t flags;

    rst_pin_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (ext_rst_n),
        .filt_low (filt_low),
        .ext_evt  (ext_evt)
    );

    lv_detect u_lv (
        .clk     (clk),
        .rst_n   (rst_n),
        .bo_en   (bo_en),
        .lv_trip (lv_trip),
        .irq_en  (lv_irq_en),
        .lv_live (lv_live),
        .lv_irq  (lv_irq)
    );

    rst_status_reg u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src),
        .stop_mode (stop_mode),
        .rd_clr    (rd_stb),
        .flags     (flags)
    );

    // Bus strobes and event priority: brownout, then pin, then watchdog
    always_comb begin
        rd_stb  = bus_sel & bus_rd;
        wr_stb  = bus_sel & bus_wr;
        bo_qual = bo_en & bo_trip;
        if (bo_qual)          src = EV_PWR;
        else if (ext_evt)     src = EV_PIN;
        else if (wdt_timeout) src = EV_WDT;
        else                  src = EV_NONE;
    end

    // Read data: status byte during a read, zero otherwise
    always_comb begin
        bus_rdata = rd_stb ? pack_status(flags, lv_live) : '0;
    end

    // Registered system reset from all active causes
    always_ff @(posedge clk) begin
        if (!rst_n) sys_rst_n <= 1'b0;
        else        sys_rst_n <= ~(bo_qual | filt_low | wdt_timeout);
    end

    // Write-only watchdog control byte
    always_ff @(posedge clk) begin
        if (!rst_n)      wdt_ctrl <= '0;
        else if (wr_stb) wdt_ctrl <= bus_wdata;
    end

    // R12
    brownout_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bo_en && bo_trip) |=> !sys_rst_n);

    // R10
    wdt_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !sys_rst_n);

    // R7
    wdt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr) |=> wdt_ctrl == $past(bus_wdata));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[3:1] == 3'b000);
endmodule

// File: tb/rst_cause_ctrl_tb.sv
module rst_cause_ctrl_tb_top;
    localparam int FILT = 4;

    logic       clk = 1'b0;
    logic       rst_n, ext_rst_n, bo_en, bo_trip, lv_trip, lv_irq_en;
    logic       wdt_timeout, stop_mode, bus_sel, bus_rd, bus_wr;
    logic [7:0] bus_wdata, bus_rdata, wdt_ctrl;
    logic       sys_rst_n, lv_irq;

    int errors = 0;
    int checks = 0;
    logic [7:0] rd_val;

    // Low-voltage table: {bo_en, lv_trip, irq_en, exp_bit0, exp_irq}
    localparam int NV = 9;
    localparam logic [4:0] LV_TAB [NV] = '{
        5'b10100, 5'b11111, 5'b11110, 5'b10100, 5'b11010,
        5'b10000, 5'b01100, 5'b11111, 5'b01100
    };

    always #5 clk = ~clk;

    rst_cause_ctrl #(.FILT_LEN(FILT)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .bo_en(bo_en),
        .bo_trip(bo_trip), .lv_trip(lv_trip), .lv_irq_en(lv_irq_en),
        .wdt_timeout(wdt_timeout), .stop_mode(stop_mode), .bus_sel(bus_sel),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sys_rst_n(sys_rst_n), .lv_irq(lv_irq),
        .wdt_ctrl(wdt_ctrl)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One read cycle; value sampled mid-cycle, flags clear at the closing edge
    task automatic do_read(output logic [7:0] v);
        bus_sel = 1'b1; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wdt_strobe();
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ext_rst_n = 1'b1; bo_en = 1'b1; bo_trip = 1'b0;
        lv_trip = 1'b0; lv_irq_en = 1'b0; wdt_timeout = 1'b0; stop_mode = 1'b0;
        bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        check("R1 sys_rst_n in reset", {7'b0, sys_rst_n}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sys_rst_n released", {7'b0, sys_rst_n}, 8'h01);
        check("R1 wdt_ctrl", wdt_ctrl, 8'h00);
        check("R2 idle rdata", bus_rdata, 8'h00);
        do_read(rd_val);
        check("R1 power-on status", rd_val, 8'h40);
        do_read(rd_val);
        check("R3 cleared by read", rd_val, 8'h00);

        // Table walk: live flag and interrupt (R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            bo_en = LV_TAB[i][4]; lv_trip = LV_TAB[i][3]; lv_irq_en = LV_TAB[i][2];
            bus_sel = 1'b1; bus_rd = 1'b1;
            #1;
            check($sformatf("R4 live bit step %0d", i), {7'b0, bus_rdata[0]}, {7'b0, LV_TAB[i][1]});
            check($sformatf("R5 irq step %0d", i), {7'b0, lv_irq}, {7'b0, LV_TAB[i][0]});
            @(negedge clk);
            bus_sel = 1'b0; bus_rd = 1'b0;
        end
        bo_en = 1'b1; lv_trip = 1'b1; lv_irq_en = 1'b0;
        do_write(8'hC3);
        do_read(rd_val);
        check("R4 live bit after write and reads", rd_val, 8'h01);
        lv_trip = 1'b0;
        @(negedge clk);

        // Watchdog (R10 R7)
        wdt_strobe();
        check("R10 sys_rst_n low after strobe", {7'b0, sys_rst_n}, 8'h00);
        @(negedge clk);
        check("R10 sys_rst_n back high", {7'b0, sys_rst_n}, 8'h01);
        do_write(8'h5A);
        check("R7 wdt_ctrl loaded", wdt_ctrl, 8'h5A);
        do_read(rd_val);
        check("R7 write leaves status", rd_val, 8'h10);

        // Event and read in the same cycle (R11)
        stop_mode = 1'b1;
        wdt_timeout = 1'b1;
        do_read(rd_val);
        wdt_timeout = 1'b0;
        check("R11 read shows previous", rd_val, 8'h00);
        do_read(rd_val);
        check("R9 R11 wdt in stop survives read", rd_val, 8'h30);
        stop_mode = 1'b0;

        // Glitch filter (R8)
        ext_rst_n = 1'b0;
        repeat (FILT - 1) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 short pulse no reset", {7'b0, sys_rst_n}, 8'h01);
        do_read(rd_val);
        check("R8 short pulse no flag", rd_val, 8'h00);
        stop_mode = 1'b1;
        ext_rst_n = 1'b0;
        repeat (FILT + 1) @(negedge clk);
        check("R8 not yet low", {7'b0, sys_rst_n}, 8'h01);
        @(negedge clk);
        check("R8 full pulse resets", {7'b0, sys_rst_n}, 8'h00);
        ext_rst_n = 1'b1;
        stop_mode = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 released", {7'b0, sys_rst_n}, 8'h01);
        do_read(rd_val);
        check("R9 pin reset in stop", rd_val, 8'hA0);

        // Brownout (R12 R11 R6)
        wdt_strobe();
        bo_trip = 1'b1;
        @(negedge clk);
        check("R12 sys_rst_n low", {7'b0, sys_rst_n}, 8'h00);
        do_read(rd_val);
        check("R12 R11 only power flag", rd_val, 8'h40);
        do_read(rd_val);
        check("R12 held while active", rd_val, 8'h40);
        bo_trip = 1'b0;
        @(negedge clk);
        check("R12 released", {7'b0, sys_rst_n}, 8'h01);
        do_read(rd_val);
        do_read(rd_val);
        check("R3 cleared after brownout", rd_val, 8'h00);
        bo_en = 1'b0; bo_trip = 1'b1; lv_trip = 1'b1; lv_irq_en = 1'b1;
        #1 check("R6 no irq when disabled", {7'b0, lv_irq}, 8'h00);
        repeat (2) @(negedge clk);
        check("R6 no reset when disabled", {7'b0, sys_rst_n}, 8'h01);
        do_read(rd_val);
        check("R6 no flag when disabled", rd_val, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule